// File: doc/BRIEF.md
# Strided Vector Load Address Generator

This block walks a vector laid out in main memory and moves it, one element at a time, into a single coprocessor register. A host sets up the walk through a small memory-mapped register window: a start address, the step between neighbouring elements, how many elements form one contiguous group, the extra step taken once a group is finished, how many elements to move in total, the pacing interval and the index of the destination register. A write to the command offset starts the walk.

While running, the block raises a read request with an address and holds it until memory returns valid data. Each accepted word is written into the destination register in the following cycle. Requests are paced so that a new element is fetched no sooner than n cycles after the previous one was accepted. When the programmed number of elements has been accepted, the block pulses a done flag and goes idle.

Top module: `vload_agen`

## Requirements
- R1: After reset, busy, done, rd_req and rf_we are all low.
- R2: Host writes with cfg_we high select a setting by cfg_sel: 0 start address, 1 element step, 2 group length, 3 group-end step, 4 element count, 5 interval n, 6 destination register index; a write to offset 7 starts a walk whose first request carries the start address.
- R3: Inside a group, each next address is the previous one plus the element step, in 32-bit two's complement with wrap-around.
- R4: After the last element of a group of length L (L nonzero), the group-end step is added instead of the element step; a group length of 0 means the walk never leaves its group.
- R5: The first request appears in the cycle after the start write; each later request appears n cycles after the previous acceptance; n of 0 behaves as n of 1.
- R6: While rd_req is high and rd_valid is low, rd_req and rd_addr hold; an element is accepted in a cycle with both high, and the interval restarts from that acceptance.
- R7: One cycle after each acceptance, rf_we is high for one cycle with rf_wdata equal to the accepted word and rf_idx equal to the destination index; rf_we is low otherwise.
- R8: done pulses for one cycle together with the write of the last element, busy falls in that same cycle, and no further request follows; with a count of 0, done pulses in the cycle after the start write and no request is made.
- R9: While busy, host writes to any offset, including offset 7, have no effect on the running walk or on later walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Host register write strobe |
| cfg_sel | input | 3 | Host register offset |
| cfg_wdata | input | ADDR_W | Host write data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory read address |
| rd_valid | input | 1 | Memory data valid, accepts the request |
| rd_data | input | DATA_W | Memory read data |
| rf_we | output | 1 | Destination register write enable |
| rf_idx | output | IDX_W | Destination register index |
| rf_wdata | output | DATA_W | Destination register write data |

## Verification
The first request is due one cycle after the start write plus the memory delay d, and every later acceptance exactly n+d cycles after the previous one; the bench tracks the index of each rising edge and compares the edge at which a request will be accepted against that figure. The register-file write and, for the last element, the done pulse and the drop of busy are due one cycle after acceptance, so the bench records each acceptance it grants and checks those outputs at the next falling edge. A count of zero is checked one cycle after the start write. Sweeps cover steps, group lengths, group-end steps, intervals, delays and counts, with addresses computed from a closed-form group/offset formula.

// File: rtl/vload_pkg.sv
package vload_pkg;
  typedef enum logic [2:0] {
    SEL_BASE  = 3'd0,
    SEL_STEP  = 3'd1,
    SEL_GLEN  = 3'd2,
    SEL_GSTEP = 3'd3,
    SEL_COUNT = 3'd4,
    SEL_IVL   = 3'd5,
    SEL_TGT   = 3'd6,
    SEL_GO    = 3'd7
  } cfg_sel_e;
endpackage

// File: rtl/vload_cfg.sv
module vload_cfg
  import vload_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int IVL_W  = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              busy,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] step,
  output logic [CNT_W-1:0]  glen,
  output logic [ADDR_W-1:0] gstep,
  output logic [CNT_W-1:0]  count,
  output logic [IVL_W-1:0]  ivl,
  output logic [IDX_W-1:0]  tgt,
  output logic              go
);
  logic wr_ok;
  assign wr_ok = we && !busy;
  assign go    = wr_ok && (cfg_sel_e'(sel) == SEL_GO);

  always_ff @(posedge clk) begin
    if (rst) begin
      base  <= '0;
      step  <= '0;
      glen  <= '0;
      gstep <= '0;
      count <= '0;
      ivl   <= '0;
      tgt   <= '0;
    end else if (wr_ok) begin
      case (cfg_sel_e'(sel))
        SEL_BASE:  base  <= wdata;
        SEL_STEP:  step  <= wdata;
        SEL_GLEN:  glen  <= wdata[CNT_W-1:0];
        SEL_GSTEP: gstep <= wdata;
        SEL_COUNT: count <= wdata[CNT_W-1:0];
        SEL_IVL:   ivl   <= wdata[IVL_W-1:0];
        SEL_TGT:   tgt   <= wdata[IDX_W-1:0];
        default: ;
      endcase
    end
  end

  p_locked_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && we) |=> $stable({base, step, glen, gstep, count, ivl, tgt}));
endmodule

// File: rtl/vload_pace.sv
module vload_pace #(
  parameter int IVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             accept,
  input  logic [IVL_W-1:0] ivl,
  output logic             expired
);
  logic [IVL_W-1:0] cnt_q;
  logic [IVL_W-1:0] reload;

  assign reload  = (ivl == '0) ? '0 : ivl - IVL_W'(1);
  assign expired = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (start)       cnt_q <= '0;
    else if (accept)      cnt_q <= reload;
    else if (cnt_q != '0) cnt_q <= cnt_q - IVL_W'(1);
  end

  p_pace_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && ivl > IVL_W'(1)) |=> !expired);
  p_pace_fast_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && ivl <= IVL_W'(1)) |=> expired);
endmodule

// File: rtl/vload_walk.sv
module vload_walk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              accept,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] step,
  input  logic [CNT_W-1:0]  glen,
  input  logic [ADDR_W-1:0] gstep,
  output logic [ADDR_W-1:0] addr
);
  logic [CNT_W-1:0] pos_q;
  logic             grp_end;

  assign grp_end = (glen != '0) && (pos_q == glen - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      pos_q <= '0;
    end else if (start) begin
      addr  <= base;
      pos_q <= '0;
    end else if (accept) begin
      if (grp_end) begin
        addr  <= addr + gstep;
        pos_q <= '0;
      end else begin
        addr  <= addr + step;
        pos_q <= pos_q + CNT_W'(1);
      end
    end
  end

  p_in_group_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && !start && glen == '0) |=> (addr == $past(addr) + $past(step)));
  p_group_end_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && !start && grp_end) |=> (addr == $past(addr) + $past(gstep)));
  p_start_addr_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (addr == $past(base)));
endmodule

// File: rtl/vload_agen.sv
module vload_agen
  import vload_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int IVL_W  = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              busy,
  output logic              done,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_idx,
  output logic [DATA_W-1:0] rf_wdata
);
  logic [ADDR_W-1:0] base, step, gstep;
  logic [CNT_W-1:0]  glen, count, left_q;
  logic [IVL_W-1:0]  ivl;
  logic [IDX_W-1:0]  tgt;
  logic              go, expired, accept, busy_q, last;

  vload_cfg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IVL_W(IVL_W), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .busy(busy_q), .base(base), .step(step), .glen(glen), .gstep(gstep),
    .count(count), .ivl(ivl), .tgt(tgt), .go(go)
  );

  vload_pace #(.IVL_W(IVL_W)) u_pace (
    .clk(clk), .rst(rst), .start(go), .accept(accept), .ivl(ivl), .expired(expired)
  );

  vload_walk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst(rst), .start(go), .accept(accept), .base(base),
    .step(step), .glen(glen), .gstep(gstep), .addr(rd_addr)
  );

  assign rd_req = busy_q && expired;
  assign accept = rd_req && rd_valid;
  assign last   = (left_q == CNT_W'(1));
  assign busy   = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      left_q   <= '0;
      done     <= 1'b0;
      rf_we    <= 1'b0;
      rf_idx   <= '0;
      rf_wdata <= '0;
    end else begin
      done  <= 1'b0;
      rf_we <= accept;
      if (accept) begin
        rf_idx   <= tgt;
        rf_wdata <= rd_data;
      end
      if (go) begin
        busy_q <= (count != '0);
        left_q <= count;
        done   <= (count == '0);
      end else if (accept) begin
        left_q <= left_q - CNT_W'(1);
        if (last) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  p_req_in_run_r8: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> busy);
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));
  p_write_after_r7: assert property (@(posedge clk) disable iff (rst)
    accept |=> rf_we);
  p_no_stray_write_r7: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !rf_we);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/test_vload_agen.sv
module test_vload_agen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        busy, done, rd_req, rf_we;
  logic [31:0] rd_addr, rf_wdata;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic [3:0]  rf_idx;

  int tests = 0, fails = 0, cyc = 0;

  // expected walk state
  logic [31:0] e_base, e_step, e_gstep;
  int e_glen = 0, e_count = 0, e_n = 1, e_d = 0, e_tgt = 0;
  int k = 0, t_last = 0, gap = 1, wait_n = 0, done_cnt = 0;
  bit active = 0, pend = 0, pend_last = 0;
  logic [31:0] pend_addr;

  vload_agen i_vload_agen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .busy(busy), .done(done), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rf_we(rf_we), .rf_idx(rf_idx),
    .rf_wdata(rf_wdata)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return (a * 32'd2654435761) ^ 32'h3C96_A50F;
  endfunction

  function automatic logic [31:0] exp_addr(int idx);
    logic [31:0] g, r;
    if (e_glen == 0) return e_base + 32'(idx) * e_step;
    g = 32'(idx / e_glen);
    r = 32'(idx % e_glen);
    return e_base + g * (32'(e_glen - 1) * e_step + e_gstep) + r * e_step;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model and output monitor
  always @(negedge clk) begin
    if (active) begin
      if (pend) begin
        check(rf_we === 1'b1, "R7", "rf_we", 32'(rf_we), 1);
        check(rf_wdata === mem_word(pend_addr), "R7", "rf_wdata", rf_wdata, mem_word(pend_addr));
        check(rf_idx === 4'(e_tgt), "R7", "rf_idx", 32'(rf_idx), 32'(e_tgt));
        check(done === pend_last, "R8", "done with write", 32'(done), 32'(pend_last));
        if (pend_last) check(busy === 1'b0, "R8", "busy after last", 32'(busy), 0);
      end else begin
        check(rf_we === 1'b0, "R7", "stray rf_we", 32'(rf_we), 0);
        check(done === 1'b0, "R8", "stray done", 32'(done), 0);
      end
      if (done === 1'b1) done_cnt++;
      pend = 0;
      if (rd_req === 1'b1) begin
        if (k >= e_count) begin
          check(0, "R8", "request after count", 32'(k), 32'(e_count));
          rd_valid <= 1'b0;
        end else begin
          check(rd_addr === exp_addr(k), "R3/R4 addr", (e_glen == 0) ? "R3" : "R4",
                rd_addr, exp_addr(k));
          if (wait_n + 1 > e_d) begin
            check(cyc + 1 - t_last == gap, "R5", "accept spacing", 32'(cyc + 1 - t_last), 32'(gap));
            rd_valid  <= 1'b1;
            rd_data   <= mem_word(rd_addr);
            pend      = 1;
            pend_addr = rd_addr;
            pend_last = (k == e_count - 1);
            k++;
            t_last = cyc + 1;
            gap    = (e_n == 0) ? 1 + e_d : e_n + e_d;
            wait_n = 0;
          end else begin
            rd_valid <= 1'b0;
            wait_n = wait_n + 1;
          end
        end
      end else begin
        rd_valid <= 1'b0;
        wait_n = 0;
      end
    end else begin
      rd_valid <= 1'b0;
    end
  end

  task automatic cfg_write(logic [2:0] sel, logic [31:0] val);
    @(negedge clk);
    if (sel == 3'd7) begin
      t_last = cyc + 1;
      gap    = 1 + e_d;
    end
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(logic [31:0] base, logic [31:0] step, int glen, logic [31:0] gstep,
                     int count, int n, int d, int tgt, bit prog, bit poke);
    if (prog) begin
      e_base = base; e_step = step; e_glen = glen; e_gstep = gstep;
      e_count = count; e_n = n; e_tgt = tgt;
      cfg_write(3'd0, base);  cfg_write(3'd1, step);
      cfg_write(3'd2, 32'(glen)); cfg_write(3'd3, gstep);
      cfg_write(3'd4, 32'(count)); cfg_write(3'd5, 32'(n));
      cfg_write(3'd6, 32'(tgt));
    end
    e_d = d; k = 0; done_cnt = 0; pend = 0; wait_n = 0;
    active = (e_count != 0);
    cfg_write(3'd7, 32'd0);
    if (e_count == 0) begin
      // negedge after start edge
      check(done === 1'b1, "R8", "done for zero count", 32'(done), 1);
      check(busy === 1'b0 && rd_req === 1'b0, "R8", "idle for zero count", 32'(busy), 0);
      @(negedge clk);
      check(done === 1'b0 && rd_req === 1'b0, "R8", "zero count pulse", 32'(done), 0);
    end else begin
      if (poke) begin
        check(busy === 1'b1, "R9", "busy during walk", 32'(busy), 1);
        cfg_write(3'd0, 32'hDEAD_0000);
        cfg_write(3'd1, 32'd99);
        cfg_write(3'd4, 32'd1);
        cfg_write(3'd7, 32'd0);
      end
      while ((k < e_count || pend) && cyc < 190000) @(negedge clk);
      repeat (3) @(negedge clk);
      check(busy === 1'b0, "R8", "idle after walk", 32'(busy), 0);
      check(done_cnt == 1, "R8", "single done", 32'(done_cnt), 1);
      check(k == e_count, "R9", "element total", 32'(k), 32'(e_count));
      active = 0;
    end
  endtask

  initial begin
    logic [31:0] steps [0:2];
    logic [31:0] gsteps [0:1];
    int          glens [0:3];
    int          ns [0:2];
    int          cnts [0:3];
    steps  = '{32'd1, 32'hFFFF_FFFE, 32'd12};
    gsteps = '{32'd64, 32'hFFFF_FFF9};
    glens  = '{0, 1, 2, 3};
    ns     = '{0, 1, 3};
    cnts   = '{0, 1, 4, 7};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy === 1'b0, "R1", "busy", 32'(busy), 0);
    check(done === 1'b0, "R1", "done", 32'(done), 0);
    check(rd_req === 1'b0, "R1", "rd_req", 32'(rd_req), 0);
    check(rf_we === 1'b0, "R1", "rf_we", 32'(rf_we), 0);

    // R2..R8 sweep
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 2; c++)
          for (int e = 0; e < 3; e++)
            for (int d = 0; d < 3; d += 2)
              for (int f = 0; f < 4; f++)
                run(32'h0000_1000 + 32'(a * 8), steps[a], glens[b], gsteps[c],
                    cnts[f], ns[e], d, (a + f) % 16, 1, 0);

    // R3 address wrap near the top of the space
    run(32'hFFFF_FFF8, 32'd4, 0, 32'd0, 5, 2, 1, 9, 1, 0);

    // R9 host writes while busy are ignored, then a rerun uses the old setup
    run(32'h0000_2000, 32'd8, 2, 32'd100, 6, 3, 1, 5, 1, 1);
    run(32'h0, 32'h0, 0, 32'h0, 0, 0, 0, 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 195000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d cycles expected fewer than 195000", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule